// File: doc/BRIEF.md
# Three-Wire Control Bus Master

This block runs transactions on a three-wire control bus built from a clock line, a data line and a mode line. Each transaction starts with a command that gives the direction, an address byte and a count of data bytes. The block then sends the address byte with the mode line held low. After that it either sends data bytes taken from a valid/ready stream or receives data bytes from the device. Each received byte is delivered with a one-cycle valid pulse.

The address byte holds a device address in bits 7:2 and a register-space selector in bits 1:0. The block passes the byte through unchanged. Every interval on the bus is a parameter counted in system-clock cycles: clock low, clock high, mode setup, mode hold and the mode halt pulse. Each pad is modelled as an output enable and an output value. The data line also has an input.

The data line changes only while the clock is low. For this reason the shared lines can never show a falling data edge while the clock is high, which another master would read as a start condition. The lines are driven high when a transaction begins and are released when it ends.

Top module: `twb_master`

## Requirements
- R1: After reset, and whenever no transaction is running, all three output enables are 0 and busy, done, wr_ready and rd_valid are 0.
- R2: In the cycle after cmd_valid is seen with busy low, busy is 1 and all three lines are driven (enable 1) to the value 1.
- R3: While the data line is driven, its value changes only in a cycle where the clock output is 0 in both that cycle and the cycle before.
- R4: Every byte is 8 clock pulses, least significant bit first, with the value taken at each rising clock edge. A transaction carries cmd_addr first and then cmd_len data bytes, for cmd_len+1 bytes in all.
- R5: The mode line is 0 at every rising clock edge of the address byte and 1 at every rising clock edge of a data byte. It changes only while the clock is 1.
- R6: Between the address byte and the first data byte, the mode line shows no low pulse.
- R7: Before the second data byte and every later data byte, the mode line is pulsed low for exactly HALT cycles while the clock stays high.
- R8: Within a bit, the clock is low for CLK_LO+1 cycles. The first of these cycles holds the old data and the remaining CLK_LO cycles hold the new bit.
- R9: When cmd_read is 1, the data-line enable goes to 0 after the address byte. The bit is sampled in the last clock-low cycle, and rd_valid pulses for one cycle per byte while rd_data holds the assembled byte.
- R10: When cmd_read is 0, wr_ready is 1 only while the block waits for the next data byte. One byte is taken per cycle where wr_valid and wr_ready are both 1, and the clock stays driven high during the wait.
- R11: done pulses for one cycle when the final hold interval ends. In that same cycle busy and all output enables fall to 0. A cmd_valid that arrives while busy is 1 has no effect.
- R12: A command with cmd_len equal to 0 sends only the address byte and then finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a transaction (taken when idle) |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 8 | Address byte (device in 7:2, register space in 1:0) |
| cmd_len | input | LEN_W | Number of data bytes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| wr_data | input | 8 | Write data byte |
| wr_valid | input | 1 | Write data byte offered |
| wr_ready | output | 1 | Block waits for a write byte |
| rd_data | output | 8 | Last received byte |
| rd_valid | output | 1 | One-cycle pulse per received byte |
| sclk_oe | output | 1 | Clock pad enable |
| sclk_o | output | 1 | Clock pad value |
| sdat_oe | output | 1 | Data pad enable |
| sdat_o | output | 1 | Data pad value |
| sdat_i | input | 1 | Data pad input |
| smode_oe | output | 1 | Mode pad enable |
| smode_o | output | 1 | Mode pad value |

## Verification
Every output comes from a register. A command is reflected on busy and the pads one cycle after the edge that sees it. rd_valid appears one cycle after the high interval of the eighth bit ends, and done appears one cycle after the last hold interval ends. The bench drives inputs and samples outputs on the falling clock edge, so every registered change is seen exactly one sample after the edge that caused it. The interval checks count samples between observed line edges and compare them with CLK_LO+1 and HALT. They do not wait fixed delays from the command. The bench waits for done itself and then checks that the lines have been released.

// File: rtl/twb_pkg.sv
package twb_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DRIVE,
        S_FETCH,
        S_HALT,
        S_SETUP,
        S_FALL,
        S_LOW,
        S_HIGH,
        S_HOLD
    } twb_state_e;

    // position of the byte within the transaction
    typedef enum logic [1:0] {
        C_ADDR,
        C_FIRST,
        C_LATER
    } twb_cls_e;
endpackage

// File: rtl/twb_tick.sv
module twb_tick #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/twb_shreg.sv
module twb_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         in_bit,
    output logic         out_bit,
    output logic [W-1:0] value
);
    logic [W-1:0] sh_d, sh_q;

    // LSB leaves first; received bits enter at the MSB end
    always_comb begin
        sh_d = sh_q;
        if (load)
            sh_d = load_val;
        else if (shift)
            sh_d = {in_bit, sh_q[W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign out_bit = sh_q[0];
    assign value   = sh_q;
endmodule

// File: rtl/twb_master.sv
module twb_master
    import twb_pkg::*;
#(
    parameter int CLK_LO  = 25,
    parameter int CLK_HI  = 25,
    parameter int MODE_SU = 19,
    parameter int MODE_HO = 19,
    parameter int HALT    = 19,
    parameter int LEN_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [BYTE_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              busy,
    output logic              done,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              sclk_oe,
    output logic              sclk_o,
    output logic              sdat_oe,
    output logic              sdat_o,
    input  logic              sdat_i,
    output logic              smode_oe,
    output logic              smode_o
);
    localparam int T_A   = (CLK_LO > CLK_HI) ? CLK_LO : CLK_HI;
    localparam int T_B   = (MODE_SU > MODE_HO) ? MODE_SU : MODE_HO;
    localparam int T_C   = (T_A > T_B) ? T_A : T_B;
    localparam int T_MAX = (T_C > HALT) ? T_C : HALT;
    localparam int CNT_W = (T_MAX < 2) ? 1 : $clog2(T_MAX);
    localparam int BIT_W = $clog2(BYTE_W);

    localparam logic [CNT_W-1:0] V_LO = CNT_W'(CLK_LO - 1);
    localparam logic [CNT_W-1:0] V_HI = CNT_W'(CLK_HI - 1);
    localparam logic [CNT_W-1:0] V_SU = CNT_W'(MODE_SU - 1);
    localparam logic [CNT_W-1:0] V_HO = CNT_W'(MODE_HO - 1);
    localparam logic [CNT_W-1:0] V_HA = CNT_W'(HALT - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    typedef struct packed {
        twb_state_e       st;
        twb_cls_e         cls;
        logic             rd;
        logic [LEN_W-1:0] left;
        logic [BIT_W-1:0] bitc;
        logic             clk_o;
        logic             dat_o;
        logic             mode_o;
        logic             clk_oe;
        logic             dat_oe;
        logic             mode_oe;
        logic             busy;
        logic             done;
        logic             rd_v;
        logic             wr_rdy;
    } ctl_t;

    ctl_t q, n;

    logic             t_ld, t_zero;
    logic [CNT_W-1:0] t_val;
    logic             s_ld, s_sh, s_out;
    logic [BYTE_W-1:0] s_val, s_word;
    twb_cls_e         nxt_cls;

    twb_tick #(.CW(CNT_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_ld),
        .load_val (t_val),
        .zero     (t_zero)
    );

    twb_shreg #(.W(BYTE_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (s_ld),
        .load_val (s_val),
        .shift    (s_sh),
        .in_bit   (sdat_i),
        .out_bit  (s_out),
        .value    (s_word)
    );

    always_comb begin
        n       = q;
        n.done  = 1'b0;
        n.rd_v  = 1'b0;
        t_ld    = 1'b0;
        t_val   = '0;
        s_ld    = 1'b0;
        s_val   = '0;
        s_sh    = 1'b0;
        nxt_cls = (q.cls == C_ADDR) ? C_FIRST : C_LATER;

        unique case (q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    n.st      = S_DRIVE;
                    n.rd      = cmd_read;
                    n.left    = cmd_len;
                    n.cls     = C_ADDR;
                    n.bitc    = '0;
                    n.clk_o   = 1'b1;
                    n.dat_o   = 1'b1;
                    n.mode_o  = 1'b1;
                    n.clk_oe  = 1'b1;
                    n.dat_oe  = 1'b1;
                    n.mode_oe = 1'b1;
                    n.busy    = 1'b1;
                    s_ld      = 1'b1;
                    s_val     = cmd_addr;
                end
            end
            S_DRIVE: begin
                // address byte: mode goes low with the clock high
                n.st     = S_SETUP;
                n.mode_o = 1'b0;
                t_ld     = 1'b1;
                t_val    = V_SU;
            end
            S_FETCH: begin
                if (wr_valid) begin
                    n.wr_rdy = 1'b0;
                    s_ld     = 1'b1;
                    s_val    = wr_data;
                    t_ld     = 1'b1;
                    if (q.cls == C_LATER) begin
                        n.st     = S_HALT;
                        n.mode_o = 1'b0;
                        t_val    = V_HA;
                    end else begin
                        n.st  = S_SETUP;
                        t_val = V_SU;
                    end
                end
            end
            S_HALT: begin
                if (t_zero) begin
                    n.st     = S_SETUP;
                    n.mode_o = 1'b1;
                    t_ld     = 1'b1;
                    t_val    = V_SU;
                end
            end
            S_SETUP: begin
                if (t_zero) begin
                    n.st    = S_FALL;
                    n.clk_o = 1'b0;
                end
            end
            S_FALL: begin
                // clock already low: the new bit may now appear
                n.st  = S_LOW;
                t_ld  = 1'b1;
                t_val = V_LO;
                if (q.dat_oe)
                    n.dat_o = s_out;
            end
            S_LOW: begin
                if (t_zero) begin
                    n.st    = S_HIGH;
                    n.clk_o = 1'b1;
                    t_ld    = 1'b1;
                    t_val   = V_HI;
                    if (!q.dat_oe)
                        s_sh = 1'b1;
                end
            end
            S_HIGH: begin
                if (t_zero) begin
                    if (q.dat_oe)
                        s_sh = 1'b1;
                    if (q.bitc == LAST_BIT) begin
                        n.st  = S_HOLD;
                        t_ld  = 1'b1;
                        t_val = V_HO;
                        if (q.cls == C_ADDR)
                            n.mode_o = 1'b1;
                        if (!q.dat_oe)
                            n.rd_v = 1'b1;
                    end else begin
                        n.st    = S_FALL;
                        n.bitc  = q.bitc + 1'b1;
                        n.clk_o = 1'b0;
                    end
                end
            end
            S_HOLD: begin
                if (t_zero) begin
                    if (q.left == '0) begin
                        n.st      = S_IDLE;
                        n.clk_oe  = 1'b0;
                        n.dat_oe  = 1'b0;
                        n.mode_oe = 1'b0;
                        n.busy    = 1'b0;
                        n.done    = 1'b1;
                    end else begin
                        n.left = q.left - 1'b1;
                        n.cls  = nxt_cls;
                        n.bitc = '0;
                        if (q.rd) begin
                            n.dat_oe = 1'b0;
                            t_ld     = 1'b1;
                            if (nxt_cls == C_LATER) begin
                                n.st     = S_HALT;
                                n.mode_o = 1'b0;
                                t_val    = V_HA;
                            end else begin
                                n.st  = S_SETUP;
                                t_val = V_SU;
                            end
                        end else begin
                            n.st     = S_FETCH;
                            n.wr_rdy = 1'b1;
                        end
                    end
                end
            end
            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy     = q.busy;
    assign done     = q.done;
    assign wr_ready = q.wr_rdy;
    assign rd_data  = s_word;
    assign rd_valid = q.rd_v;
    assign sclk_oe  = q.clk_oe;
    assign sclk_o   = q.clk_o;
    assign sdat_oe  = q.dat_oe;
    assign sdat_o   = q.dat_o;
    assign smode_oe = q.mode_oe;
    assign smode_o  = q.mode_o;
endmodule

// File: rtl/twb_master_chk.sv
module twb_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       busy,
    input logic       done,
    input logic       wr_valid,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       sclk_oe,
    input logic       sclk_o,
    input logic       sdat_oe,
    input logic       sdat_o,
    input logic       smode_oe,
    input logic       smode_o
);
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk_oe && !sdat_oe && !smode_oe && !wr_ready && !rd_valid));

    assert_start_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> (busy && sclk_oe && sdat_oe && smode_oe
                                  && sclk_o && sdat_o && smode_o));

    assert_data_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sdat_oe && $past(sdat_oe) && (sdat_o != $past(sdat_o)))
            |-> (!sclk_o && !$past(sclk_o)));

    assert_mode_clk_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smode_oe && $past(smode_oe) && (smode_o != $past(smode_o)))
            |-> (sclk_o && $past(sclk_o)));

    assert_rd_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !sdat_oe);

    assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_wr_stall_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (sclk_oe && sclk_o && busy));

    assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && !wr_valid) |=> wr_ready);

    assert_done_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !sclk_oe && !sdat_oe && !smode_oe));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind twb_master twb_master_chk u_chk (.*);

// File: tb/sim_twb_master.sv
module sim_twb_master;
    localparam int LO = 3, HI = 2, SU = 2, HO = 2, HA = 3;

    // {read(8), addr, len, d0, d1, d2}
    localparam int NV = 5;
    localparam logic [47:0] VEC [NV] = '{
        48'h00_5A_01_A5_00_00,
        48'h00_3C_03_01_80_7E,
        48'h01_96_02_C3_18_00,
        48'h01_01_03_55_AA_F0,
        48'h00_FF_00_00_00_00
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       cmd_valid = 0, cmd_read = 0;
    logic [7:0] cmd_addr = 0, cmd_len = 0;
    logic       busy, done, wr_ready, rd_valid;
    logic [7:0] wr_data = 0, rd_data;
    logic       wr_valid = 0;
    logic       sclk_oe, sclk_o, sdat_oe, sdat_o, sdat_i = 0, smode_oe, smode_o;

    twb_master #(.CLK_LO(LO), .CLK_HI(HI), .MODE_SU(SU), .MODE_HO(HO),
                 .HALT(HA), .LEN_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .busy(busy), .done(done),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .sclk_oe(sclk_oe), .sclk_o(sclk_o),
        .sdat_oe(sdat_oe), .sdat_o(sdat_o), .sdat_i(sdat_i),
        .smode_oe(smode_oe), .smode_o(smode_o)
    );

    int errors = 0, checks = 0;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // bus observer state
    int nbits, low_run, pulse_cnt, last_plen, run, nrd, ndone, widx, wdly;
    bit bits_low;
    logic prev_clk, prev_coe, prev_dat, prev_doe, prev_mode, prev_moe;
    logic [7:0] cap [8];
    int mlow [8], pls [8], plen [8];
    logic [7:0] rdq [8];
    logic [7:0] wbuf [4];
    logic [7:0] rbuf [4];

    task automatic clear_mon();
        nbits = 0; low_run = 0; pulse_cnt = 0; last_plen = 0; run = 0;
        nrd = 0; ndone = 0; widx = 0; wdly = 2; bits_low = 0;
        for (int i = 0; i < 8; i++) begin
            cap[i] = 0; mlow[i] = 0; pls[i] = 0; plen[i] = 0; rdq[i] = 0;
        end
    endtask

    // observer, write source and read-side device, all on the falling edge
    initial begin
        clear_mon();
        prev_clk = 0; prev_coe = 0; prev_dat = 0; prev_doe = 0; prev_mode = 0; prev_moe = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                // R3: data moves only inside a clock-low stretch
                if (sdat_oe && prev_doe && sdat_o != prev_dat)
                    check_eq("R3", "clock at data change", int'(sclk_o | prev_clk), 0);
                if (sclk_oe && !sclk_o) low_run++;
                if (sclk_oe && prev_coe && sclk_o && !prev_clk) begin
                    check_eq("R8", "clock low cycles", low_run, LO + 1);
                    low_run = 0;
                    if (nbits < 64) begin
                        if (nbits % 8 == 0) begin
                            pls[nbits/8]  = pulse_cnt;
                            plen[nbits/8] = last_plen;
                            pulse_cnt = 0;
                        end
                        cap[nbits/8][nbits%8] = sdat_oe ? sdat_o : sdat_i;
                        if (!smode_o) begin
                            mlow[nbits/8]++;
                            bits_low = 1;
                        end
                    end
                    nbits++;
                end
                if (smode_oe) begin
                    if (!smode_o) begin
                        if (prev_mode) begin run = 0; bits_low = 0; end
                        run++;
                    end else if (!prev_mode && prev_moe && !bits_low) begin
                        pulse_cnt++;
                        last_plen = run;
                    end
                end
                if (rd_valid && nrd < 8) begin rdq[nrd] = rd_data; nrd++; end
                if (done) ndone++;
                if (wr_ready && widx < 4) begin
                    if (wdly > 0) begin wdly--; wr_valid = 0; end
                    else begin wr_valid = 1; wr_data = wbuf[widx]; widx++; wdly = 2; end
                end else wr_valid = 0;
                if (busy && !sdat_oe && nbits >= 8 && (nbits - 8) / 8 < 4)
                    sdat_i = rbuf[(nbits-8)/8][(nbits-8)%8];
            end
            prev_clk = sclk_o; prev_coe = sclk_oe; prev_dat = sdat_o;
            prev_doe = sdat_oe; prev_mode = smode_o; prev_moe = smode_oe;
        end
    end

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic run_vec(input logic rd, input logic [7:0] a, input logic [7:0] n,
                           input logic [23:0] d, input bit poke);
        int t;
        clear_mon();
        for (int k = 0; k < 3; k++) begin
            wbuf[k] = d[23-8*k -: 8];
            rbuf[k] = d[23-8*k -: 8];
        end
        wbuf[3] = 0; rbuf[3] = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_read = rd; cmd_addr = a; cmd_len = n;
        @(negedge clk);
        cmd_valid = 0;
        check_eq("R2", "busy/oe/values after command",
                 {busy, sclk_oe, sdat_oe, smode_oe, sclk_o, sdat_o, smode_o}, 7'h7F);
        if (poke) begin
            repeat (6) @(negedge clk);
            cmd_valid = 1; cmd_read = 1; cmd_addr = 8'h00; cmd_len = 8'd7;
            @(negedge clk);
            cmd_valid = 0;
        end
        t = 0;
        while (ndone == 0 && t < 20000) begin @(negedge clk); t++; end
        check_eq("R11", "done pulses seen", ndone, 1);
        @(negedge clk);
        check_eq("R11", "released after done",
                 {busy, sclk_oe, sdat_oe, smode_oe, done}, 0);
        check_eq("R4", "bits on bus", nbits, 8 * (int'(n) + 1));
        check_eq("R4", "address byte", cap[0], a);
        check_eq("R5", "mode-low bits in address byte", mlow[0], 8);
        for (int k = 1; k <= int'(n); k++) begin
            check_eq(rd ? "R9" : "R4", "data byte", cap[k], d[23-8*(k-1) -: 8]);
            check_eq("R5", "mode-low bits in data byte", mlow[k], 0);
            if (k == 1) check_eq("R6", "pulses before first data byte", pls[k], 0);
            else begin
                check_eq("R7", "pulses before later byte", pls[k], 1);
                check_eq("R7", "halt pulse length", plen[k], HA);
            end
        end
        if (rd) begin
            check_eq("R9", "rd_valid count", nrd, int'(n));
            for (int k = 0; k < int'(n); k++)
                check_eq("R9", "received byte", rdq[k], d[23-8*k -: 8]);
        end else begin
            check_eq("R10", "write bytes taken", widx, int'(n));
            check_eq("R9", "no rd_valid on write", nrd, 0);
        end
        if (n == 0) check_eq("R12", "address-only byte count", nbits, 8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1", "outputs in reset",
                 {sclk_oe, sdat_oe, smode_oe, busy, done, wr_ready, rd_valid}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check_eq("R1", "idle after reset",
                 {sclk_oe, sdat_oe, smode_oe, busy, done, wr_ready, rd_valid}, 0);

        for (int v = 0; v < NV; v++)
            run_vec(VEC[v][40], VEC[v][39:32], VEC[v][31:24], VEC[v][23:0], 1'b0);

        // R11: command during a transaction is ignored
        run_vec(1'b0, 8'hC5, 8'd2, 24'h6E_91_00, 1'b1);
        repeat (20) @(negedge clk);
        check_eq("R11", "no transaction from ignored command", {busy, sclk_oe}, 0);

        // R12 after a read: address-only read leaves data released at the end
        run_vec(1'b1, 8'h42, 8'd0, 24'h0, 1'b0);
        check_eq("R1", "idle after last run", {busy, wr_ready, rd_valid}, 0);
        finish_up();
    end
endmodule